// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether the running task may touch an I/O port. A request gives a 16-bit port number, a size code (one, two or four bytes), the current privilege level (CPL) and the I/O privilege level (IOPL) taken from the flags register, and a flag that says whether protected mode is on. Privilege levels run from 0, the most trusted, to 3, the least trusted.

There are two stages. The first compares privilege levels. A task at or above the I/O privilege level is granted access at once. The same applies to any access made outside protected mode. In every other case the block reads a permission bitmap through a byte-wide read port. The bitmap holds one bit for each port address, eight ports per byte, and starts at a supplied base address. A multi-byte access may cover two bitmap bytes, and the block then reads both. Bitmap bytes at or past a supplied limit are never read; they count as all ones. The verdict is either allow or general-protection fault, and it comes with a one-cycle done strobe.

Top module: `io_perm_check`

## Requirements
- R1: After reset, done, allow, gpFault, busy and memRdEn are all low.
- R2: When protMode is low, every request with a legal size code is allowed and no bitmap byte is read.
- R3: When cpl <= iopl, every request with a legal size code is allowed without a bitmap read. The done strobe comes in the second cycle after the accepting clock edge.
- R4: When protMode is high and cpl > iopl, port p is checked against bit (p mod 8) of the bitmap byte at mapBase + floor(p/8). A bit value of 0 permits the port and a value of 1 denies it.
- R5: reqSize codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. An access of n bytes is allowed only if the bits for ports p through p+n-1 are all 0.
- R6: When the span crosses a bitmap byte boundary, two bytes are read: first mapBase+i, then mapBase+i+1. This includes port 0xFFFF, whose span reaches byte index 8192.
- R7: A bitmap byte whose index is at or above mapLimit is treated as 0xFF, and no read is issued for it.
- R8: done is a single-cycle pulse. While done is high, exactly one of allow and gpFault is high; both are low otherwise.
- R9: reqSize code 3 is illegal. It always faults and never reads the bitmap, whatever the privilege or mode.
- R10: A request presented while busy is high is ignored.
- R11: memRdEn stays high, with memRdAddr unchanged, until memRdValid returns the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqPort | input | 16 | Port address |
| reqSize | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=illegal |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| protMode | input | 1 | High when protected mode is on |
| mapBase | input | 32 | Byte address of bitmap byte 0 |
| mapLimit | input | 14 | Number of bitmap bytes that exist |
| busy | output | 1 | A request is being processed |
| memRdEn | output | 1 | Bitmap read request |
| memRdAddr | output | 32 | Bitmap byte address |
| memRdData | input | 8 | Returned bitmap byte |
| memRdValid | input | 1 | memRdData is valid |
| done | output | 1 | Verdict strobe |
| allow | output | 1 | Access permitted (with done) |
| gpFault | output | 1 | General-protection fault (with done) |

## Verification
The hardest cases to reach are four-byte accesses at the top of the port space. Their span passes 0xFFFF into bitmap byte 8192, so they need both a second read and a limit compare at the extreme index. The stimulus table sets up these cases with a bitmap model whose last bytes carry distinct patterns. It runs one such case with a limit that exactly covers byte 8192 and another with a limit one below, and the read count and read addresses show which bytes were fetched. A read-latency knob in the model stretches the handshake so the hold behaviour of the read request can be checked. A second request driven during the busy window shows that it is dropped.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD0,
    ST_RD1,
    ST_DONE
  } iopState_t;

  typedef struct packed {
    logic capture;  // latch a new request
    logic load0;    // store returned byte as low bitmap byte
    logic ones0;    // force low bitmap byte to all ones
    logic load1;    // store returned byte as high bitmap byte
    logic ones1;    // force high bitmap byte to all ones
    logic sel1;     // address the high bitmap byte
  } iopStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;
  localparam logic [1:0] SZ_ILLEGAL = 2'd3;
endpackage

// File: rtl/iop_datapath.sv
module iop_datapath
  import iop_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32,
  parameter int LIM_W  = PORT_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  iopStrobe_t        stb,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic              protMode,
  input  logic [ADDR_W-1:0] mapBase,
  input  logic [LIM_W-1:0]  mapLimit,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              sizeBad,
  output logic              privOk,
  output logic              crossing,
  output logic              inLimit0,
  output logic              inLimit1,
  output logic              verdict
);
  logic [PORT_W-1:0] portQ;
  logic [1:0]        sizeQ;
  logic [1:0]        cplQ, ioplQ;
  logic              pmQ;
  logic [ADDR_W-1:0] baseQ;
  logic [LIM_W-1:0]  limitQ;
  logic [7:0]        byte0Q, byte1Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ  <= '0;
      sizeQ  <= '0;
      cplQ   <= '0;
      ioplQ  <= '0;
      pmQ    <= 1'b0;
      baseQ  <= '0;
      limitQ <= '0;
      byte0Q <= '0;
      byte1Q <= '0;
    end else begin
      if (stb.capture) begin
        portQ  <= reqPort;
        sizeQ  <= reqSize;
        cplQ   <= cpl;
        ioplQ  <= iopl;
        pmQ    <= protMode;
        baseQ  <= mapBase;
        limitQ <= mapLimit;
        byte0Q <= '0;
        byte1Q <= '0;
      end
      if (stb.load0) byte0Q <= memRdData;
      if (stb.ones0) byte0Q <= 8'hFF;
      if (stb.load1) byte1Q <= memRdData;
      if (stb.ones1) byte1Q <= 8'hFF;
    end
  end

  logic [3:0]      bitRun;
  logic [1:0]      extra;
  logic [PORT_W:0] spanLast;
  logic [LIM_W-1:0] idx0, idx1;
  logic [15:0]     mask;

  always_comb begin
    unique case (sizeQ)
      SZ_WORD:  begin bitRun = 4'b0011; extra = 2'd1; end
      SZ_DWORD: begin bitRun = 4'b1111; extra = 2'd3; end
      default:  begin bitRun = 4'b0001; extra = 2'd0; end
    endcase
  end

  assign spanLast = {1'b0, portQ} + {{(PORT_W - 1){1'b0}}, extra};
  assign idx0     = LIM_W'(portQ >> 3);
  assign idx1     = LIM_W'(spanLast >> 3);
  assign mask     = {12'b0, bitRun} << portQ[2:0];

  assign sizeBad  = (sizeQ == SZ_ILLEGAL);
  assign privOk   = !pmQ || (cplQ <= ioplQ);
  assign crossing = (idx0 != idx1);
  assign inLimit0 = (idx0 < limitQ);
  assign inLimit1 = (idx1 < limitQ);
  assign memRdAddr = baseQ + ADDR_W'(stb.sel1 ? idx1 : idx0);
  assign verdict  = !sizeBad && (privOk || ((mask & {byte1Q, byte0Q}) == 16'b0));
endmodule

// File: rtl/iop_control.sv
module iop_control
  import iop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       sizeBad,
  input  logic       privOk,
  input  logic       crossing,
  input  logic       inLimit0,
  input  logic       inLimit1,
  input  logic       memRdValid,
  output iopStrobe_t stb,
  output logic       memRdEn,
  output logic       busy,
  output logic       finish
);
  iopState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    memRdEn   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (sizeBad || privOk) stateNext = ST_DONE;
        else                   stateNext = ST_RD0;
      end
      ST_RD0: begin
        if (!inLimit0) begin
          stb.ones0 = 1'b1;
          stateNext = crossing ? ST_RD1 : ST_DONE;
        end else begin
          memRdEn = 1'b1;
          if (memRdValid) begin
            stb.load0 = 1'b1;
            stateNext = crossing ? ST_RD1 : ST_DONE;
          end
        end
      end
      ST_RD1: begin
        stb.sel1 = 1'b1;
        if (!inLimit1) begin
          stb.ones1 = 1'b1;
          stateNext = ST_DONE;
        end else begin
          memRdEn = 1'b1;
          if (memRdValid) begin
            stb.load1 = 1'b1;
            stateNext = ST_DONE;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign finish = (state == ST_DONE);
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import iop_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32,
  localparam int LIM_W = PORT_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic              protMode,
  input  logic [ADDR_W-1:0] mapBase,
  input  logic [LIM_W-1:0]  mapLimit,
  output logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  input  logic              memRdValid,
  output logic              done,
  output logic              allow,
  output logic              gpFault
);
  iopStrobe_t stb;
  logic sizeBad, privOk, crossing, inLimit0, inLimit1, verdict, finish;

  iop_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .sizeBad(sizeBad), .privOk(privOk), .crossing(crossing),
    .inLimit0(inLimit0), .inLimit1(inLimit1), .memRdValid(memRdValid),
    .stb(stb), .memRdEn(memRdEn), .busy(busy), .finish(finish)
  );

  iop_datapath #(.PORT_W(PORT_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqPort(reqPort), .reqSize(reqSize), .cpl(cpl), .iopl(iopl),
    .protMode(protMode), .mapBase(mapBase), .mapLimit(mapLimit),
    .memRdData(memRdData), .memRdAddr(memRdAddr),
    .sizeBad(sizeBad), .privOk(privOk), .crossing(crossing),
    .inLimit0(inLimit0), .inLimit1(inLimit1), .verdict(verdict)
  );

  assign done    = finish;
  assign allow   = finish && verdict;
  assign gpFault = finish && !verdict;
endmodule

// File: rtl/iop_checker.sv
module iop_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqSize,
  input logic [1:0]        cpl,
  input logic [1:0]        iopl,
  input logic              protMode,
  input logic              busy,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdValid,
  input logic              done,
  input logic              allow,
  input logic              gpFault
);
  logic takeReq;
  assign takeReq = reqValid && !busy;

  p_fast_allow_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeReq && reqSize != 2'd3 && (!protMode || cpl <= iopl) |=> ##1 (done && allow));

  p_illegal_size_r9: assert property (@(posedge clk) disable iff (!rstN)
    takeReq && reqSize == 2'd3 |=> ##1 (done && gpFault));

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (allow != gpFault));

  p_quiet_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!allow && !gpFault));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && !memRdValid |=> memRdEn && $stable(memRdAddr));

  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRdEn);
endmodule

bind io_perm_check iop_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
  .cpl(cpl), .iopl(iopl), .protMode(protMode), .busy(busy),
  .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
  .done(done), .allow(allow), .gpFault(gpFault)
);

// File: tb/tb_io_perm_check.sv
module tb_io_perm_check;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [13:0] FULL = 14'd8193;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, reqValid, protMode, busy, memRdEn, memRdValid, done, allow, gpFault;
  logic [15:0] reqPort;
  logic [1:0]  reqSize, cpl, iopl;
  logic [31:0] mapBase, memRdAddr;
  logic [13:0] mapLimit;
  logic [7:0]  memRdData;

  io_perm_check dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqSize(reqSize), .cpl(cpl), .iopl(iopl), .protMode(protMode),
    .mapBase(mapBase), .mapLimit(mapLimit), .busy(busy), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memRdValid(memRdValid),
    .done(done), .allow(allow), .gpFault(gpFault)
  );

  // Bitmap model: all bytes deny except a few chosen patterns
  function automatic logic [7:0] byteOf(input logic [31:0] idx);
    case (idx)
      32'd0:    return 8'h04;
      32'd1:    return 8'h80;
      32'd2:    return 8'h00;
      32'd8191: return 8'h7F;
      32'd8192: return 8'h00;
      default:  return 8'hFF;
    endcase
  endfunction

  int          latency = 0;
  int          waitCnt = 0;
  int          readTotal = 0;
  logic [31:0] addrLast = '0, addrPrev = '0, heldAddr = '0;
  logic        addrMoved = 1'b0;

  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (memRdEn && !memRdValid) begin
      if (waitCnt != 0 && memRdAddr != heldAddr) addrMoved <= 1'b1;
      heldAddr <= memRdAddr;
      if (waitCnt < latency) waitCnt <= waitCnt + 1;
      else begin
        memRdValid <= 1'b1;
        memRdData  <= byteOf(memRdAddr - BASE);
        waitCnt    <= 0;
        readTotal  <= readTotal + 1;
        addrPrev   <= addrLast;
        addrLast   <= memRdAddr;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runReq(input logic [15:0] p, input logic [1:0] s, input logic [1:0] c,
                        input logic [1:0] io, input logic pm, input logic [13:0] lim,
                        output logic gotAllow, output logic gotFault,
                        output int nReads, output int cyc);
    int startReads;
    @(negedge clk);
    startReads = readTotal;
    reqPort = p; reqSize = s; cpl = c; iopl = io; protMode = pm; mapLimit = lim;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    gotAllow = allow;
    gotFault = gpFault;
    nReads = readTotal - startReads;
  endtask

  // {port16, size2, cpl2, iopl2, pm1, limit14, expAllow1, expReads2}
  localparam int NV = 20;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0002, 2'd0, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b0, 2'd1},  // R4 denied bit
    {16'h0003, 2'd0, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b1, 2'd1},  // R4 permitted bit
    {16'h0000, 2'd1, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b1, 2'd1},  // R5 word ok
    {16'h0001, 2'd2, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b0, 2'd1},  // R5 dword hits port 2
    {16'h0004, 2'd2, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b1, 2'd1},  // R5 dword ok
    {16'h0006, 2'd2, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b1, 2'd2},  // R6 crossing ok
    {16'h000E, 2'd1, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b0, 2'd1},  // R5 word hits port 15
    {16'h000F, 2'd1, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b0, 2'd2},  // R6 crossing denied
    {16'h0010, 2'd2, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b1, 2'd1},  // R5 aligned dword
    {16'hFFFF, 2'd0, 2'd3, 2'd1, 1'b1, 14'd8193, 1'b1, 2'd1},  // R4 top port
    {16'hFFFF, 2'd2, 2'd3, 2'd1, 1'b1, 14'd8193, 1'b1, 2'd2},  // R6 span into byte 8192
    {16'hFFFF, 2'd2, 2'd3, 2'd1, 1'b1, 14'd8192, 1'b0, 2'd1},  // R7 byte 8192 past limit
    {16'h0003, 2'd0, 2'd3, 2'd0, 1'b1, 14'd0,    1'b0, 2'd0},  // R7 limit zero
    {16'h0002, 2'd0, 2'd1, 2'd1, 1'b1, 14'd8193, 1'b1, 2'd0},  // R3 equal levels
    {16'h0002, 2'd2, 2'd0, 2'd3, 1'b1, 14'd8193, 1'b1, 2'd0},  // R3 more trusted
    {16'h0002, 2'd0, 2'd3, 2'd0, 1'b0, 14'd8193, 1'b1, 2'd0},  // R2 real mode
    {16'h0003, 2'd3, 2'd0, 2'd3, 1'b1, 14'd8193, 1'b0, 2'd0},  // R9 privileged
    {16'h0003, 2'd3, 2'd3, 2'd0, 1'b0, 14'd8193, 1'b0, 2'd0},  // R9 real mode
    {16'h0020, 2'd0, 2'd2, 2'd1, 1'b1, 14'd8193, 1'b0, 2'd1},  // R4 default deny byte
    {16'h0016, 2'd2, 2'd3, 2'd0, 1'b1, 14'd8193, 1'b0, 2'd2}   // R6 second byte denies
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, f;
    int n, cyc, dones;
    rstN = 1'b0; reqValid = 1'b0; reqPort = '0; reqSize = '0; cpl = '0; iopl = '0;
    protMode = 1'b0; mapBase = BASE; mapLimit = FULL;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !allow && !gpFault, "R1 reset verdict outputs", {done, allow, gpFault}, 0);
    chk(!busy && !memRdEn, "R1 reset busy/read", {busy, memRdEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !memRdEn, "R1 after release", {done, busy, memRdEn}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      logic [31:0] i0;
      v = VEC[i];
      runReq(v[39:24], v[23:22], v[21:20], v[19:18], v[17], v[16:3], a, f, n, cyc);
      i0 = BASE + 32'(v[39:27]);
      chk(cyc < 60, $sformatf("vector %0d R8 done seen", i), cyc, 0);
      chk(a == v[2] && f == !v[2],
          $sformatf("vector %0d R2 R3 R4 R5 R6 R7 R9 verdict", i), {a, f}, {v[2], !v[2]});
      chk(n == int'(v[1:0]), $sformatf("vector %0d R7 read count", i), n, v[1:0]);
      if (v[1:0] == 2'd1)
        chk(addrLast == i0, $sformatf("vector %0d R4 read addr", i), addrLast, i0);
      if (v[1:0] == 2'd2) begin
        chk(addrPrev == i0, $sformatf("vector %0d R6 first addr", i), addrPrev, i0);
        chk(addrLast == i0 + 1, $sformatf("vector %0d R6 second addr", i), addrLast, i0 + 1);
      end
      @(negedge clk);
      chk(!done, $sformatf("vector %0d R8 pulse width", i), done, 0);
    end

    // R3 fast-path latency: done on the second cycle after acceptance
    runReq(16'h0040, 2'd0, 2'd0, 2'd0, 1'b1, FULL, a, f, n, cyc);
    chk(cyc == 2 && a, "R3 latency", cyc, 2);

    // R11 stalled memory: latency of 3 extra cycles per byte
    latency = 3;
    runReq(16'h0006, 2'd2, 2'd3, 2'd0, 1'b1, FULL, a, f, n, cyc);
    chk(a && n == 2, "R11 stalled result", {a, 6'(n)}, {1'b1, 6'd2});
    chk(!addrMoved, "R11 address held", addrMoved, 0);
    latency = 0;

    // R10 second request while busy must be dropped
    @(negedge clk);
    reqPort = 16'h0002; reqSize = 2'd0; cpl = 2'd3; iopl = 2'd0; protMode = 1'b1;
    mapLimit = FULL; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqPort = 16'h0003; cpl = 2'd0; iopl = 2'd3;  // would allow if taken
    dones = 0; a = 1'b0; f = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (done) begin
        dones++; a = allow; f = gpFault;
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(dones == 1, "R10 one verdict", dones, 1);
    chk(!a && f, "R10 first request kept", {a, f}, 2'b01);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule